// File: doc/BRIEF.md
# Dual-Port On-Chip SRAM Controller

This block holds a 4 KB on-chip SRAM that two requesters share: an instruction-fetch port and a data load/store port. Each port has its own 64 MB address window and its own enable bit. A window hits when the top six bits of the untranslated 32-bit address match that port's programmed base. Inside a window, the 4 KB array repeats, so every 4 KB image maps to the same physical bytes. Both windows reach the same storage, whether they are placed on one 64 MB region or on two.

The data port handles byte, halfword and word accesses. A per-access flag selects little-endian byte order, which reverses the bytes of the accessed item. The fetch port always reads big-endian. It returns either one word or an aligned pair of words on a 64-bit bus. The array has a single access slot per cycle. When both ports request it in the same cycle, the data port wins and the fetch port waits. Read data appears one cycle after a request is accepted. A small register interface holds the two base fields and the two enables.

Top module: `ocm_dual_sram`

## Requirements
- R1: After reset, both configuration registers read as zero, and neither port accepts any access: `d_ack` and `if_ready` are 0, and any data request raises `d_miss`.
- R2: A write with `cfg_we` high stores `cfg_wdata` into the register chosen by `cfg_sel` (0 = fetch, 1 = data). The base is bits [31:26] and the enable is bit 0. `cfg_rdata` returns the selected register with all other bits zero.
- R3: A data request is acknowledged in the same cycle (`d_ack`=1) only when the data enable is 1 and address bits [31:26] equal the data base. In every other case `d_miss`=1 and nothing is stored.
- R4: Address bits [25:12] are ignored. Any alias inside a window, and either port, reaches the same byte selected by bits [11:0].
- R5: Memory is byte-addressed in big-endian order. A big-endian word access at offset 0 places the byte at offset 0 in bits [31:24].
- R6: `d_size` selects 0 = byte, 1 = halfword, 2 = word. Data is right-justified in `d_wdata` and `d_rdata`. A halfword ignores address bit 0, and a word ignores bits [1:0].
- R7: With `d_le`=1, the bytes of a halfword or word access are reversed on both read and write. Byte accesses are not affected.
- R8: The fetch port ignores address bits [1:0]. A single fetch returns the addressed word in `if_rdata[63:32]` with the low half zero. A double fetch (`if_dbl`=1) also ignores bit 2 and returns the lower-addressed word in bits [63:32].
- R9: `if_ready` is high only when `if_req` is high, the fetch enable is 1, and address bits [31:26] equal the fetch base.
- R10: When a data request is acknowledged in a cycle, `if_ready` is 0 in that cycle. The fetch is accepted in a later cycle once the data port is idle.
- R11: An accepted data read raises `d_rvalid` with its data in the next cycle, and an accepted data write does not. An accepted fetch raises `if_valid` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 1 | Register select: 0 fetch, 1 data |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Selected configuration register |
| d_req | input | 1 | Data access request |
| d_we | input | 1 | Data access is a write |
| d_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| d_le | input | 1 | Little-endian byte order for this access |
| d_addr | input | 32 | Data effective address |
| d_wdata | input | 32 | Right-justified store data |
| d_ack | output | 1 | Data access claimed and performed |
| d_miss | output | 1 | Data access not claimed |
| d_rvalid | output | 1 | Load data valid |
| d_rdata | output | 32 | Right-justified load data |
| if_req | input | 1 | Fetch request |
| if_dbl | input | 1 | Fetch two words |
| if_addr | input | 32 | Fetch effective address |
| if_ready | output | 1 | Fetch accepted this cycle |
| if_valid | output | 1 | Fetch data valid |
| if_rdata | output | 64 | Fetch data |

## Verification
On every cycle, the assertions check that the block's output behaviour holds. A claim and a miss never occur together. A disabled data side never acknowledges. A fetch is never accepted in the cycle a data access is claimed. Every accepted read or fetch produces its valid strobe one cycle later. Only the bench scenarios can show the data-level behaviour: byte-lane placement, the little-endian reversal, aliasing across 4 KB images, and the fact that the two ports share storage. The bench does this by writing through one port and reading back through both.

// File: rtl/ocm_dual_sram.sv
module ocm_dual_sram #(
  parameter int BYTES    = 4096,
  parameter int WIN_BITS = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        d_req,
  input  logic        d_we,
  input  logic [1:0]  d_size,
  input  logic        d_le,
  input  logic [31:0] d_addr,
  input  logic [31:0] d_wdata,
  output logic        d_ack,
  output logic        d_miss,
  output logic        d_rvalid,
  output logic [31:0] d_rdata,
  input  logic        if_req,
  input  logic        if_dbl,
  input  logic [31:0] if_addr,
  output logic        if_ready,
  output logic        if_valid,
  output logic [63:0] if_rdata
);
  localparam int ROWS = BYTES / 8;
  localparam int IDXW = $clog2(ROWS);
  localparam int OFFW = IDXW + 3;
  localparam int PADW = 32 - WIN_BITS - 1;

  logic [WIN_BITS-1:0] ibase, dbase;
  logic                ien, den;
  logic [63:0]         mem [ROWS];
  logic [63:0]         q;
  logic [2:0]          rd_off;
  logic [1:0]          rd_size;
  logic                rd_le, rd_dbl, rd_iw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ibase <= '0; ien <= 1'b0; dbase <= '0; den <= 1'b0;
    end else if (cfg_we) begin
      if (cfg_sel) begin
        dbase <= cfg_wdata[31 -: WIN_BITS]; den <= cfg_wdata[0];
      end else begin
        ibase <= cfg_wdata[31 -: WIN_BITS]; ien <= cfg_wdata[0];
      end
    end
  end

  assign cfg_rdata = cfg_sel ? {dbase, {PADW{1'b0}}, den} : {ibase, {PADW{1'b0}}, ien};

  assign d_ack    = d_req & den & (d_addr[31 -: WIN_BITS] == dbase);
  assign d_miss   = d_req & ~d_ack;
  assign if_ready = if_req & ien & (if_addr[31 -: WIN_BITS] == ibase) & ~d_ack;

  function automatic logic [31:0] swap(input logic [1:0] sz, input logic [31:0] v);
    case (sz)
      2'd0:    return v;
      2'd1:    return {16'h0, v[7:0], v[15:8]};
      default: return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endcase
  endfunction

  logic [31:0] wval, w32;
  logic [3:0]  be4;
  logic [7:0]  be8;
  always_comb begin
    wval = d_le ? swap(d_size, d_wdata) : d_wdata;
    case (d_size)
      2'd0:    begin w32 = {4{wval[7:0]}};  be4 = 4'b1000 >> d_addr[1:0]; end
      2'd1:    begin w32 = {2{wval[15:0]}}; be4 = d_addr[1] ? 4'b0011 : 4'b1100; end
      default: begin w32 = wval;            be4 = 4'b1111; end
    endcase
    be8 = d_addr[2] ? {4'b0, be4} : {be4, 4'b0};
  end

  wire [IDXW-1:0] didx = d_addr[OFFW-1:3];
  wire [IDXW-1:0] iidx = if_addr[OFFW-1:3];

  always_ff @(posedge clk) begin
    if (d_ack && d_we) begin
      for (int b = 0; b < 8; b++)
        if (be8[b]) mem[didx][b*8 +: 8] <= w32[(b%4)*8 +: 8];
    end
    q <= mem[d_ack ? didx : iidx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_rvalid <= 1'b0; if_valid <= 1'b0;
    end else begin
      d_rvalid <= d_ack & ~d_we;
      if_valid <= if_ready;
    end
    rd_off <= d_addr[2:0]; rd_size <= d_size; rd_le <= d_le;
    rd_dbl <= if_dbl;      rd_iw   <= if_addr[2];
  end

  logic [31:0] rword, raw;
  always_comb begin
    rword = rd_off[2] ? q[31:0] : q[63:32];
    case (rd_size)
      2'd0:    raw = {24'h0, rword[8*(3-rd_off[1:0]) +: 8]};
      2'd1:    raw = {16'h0, rd_off[1] ? rword[15:0] : rword[31:16]};
      default: raw = rword;
    endcase
  end
  assign d_rdata  = rd_le ? swap(rd_size, raw) : raw;
  assign if_rdata = rd_dbl ? q : {(rd_iw ? q[31:0] : q[63:32]), 32'h0};

  logic unused_bits;
  assign unused_bits = ^{cfg_wdata[PADW:1], d_addr[31-WIN_BITS:OFFW], if_addr[31-WIN_BITS:OFFW], if_addr[1:0]};

  p_claim_excl_r3: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({d_ack, d_miss}));
  p_disabled_r3:   assert property (@(posedge clk) disable iff (!rst_n) !den |-> !d_ack);
  p_fetch_en_r9:   assert property (@(posedge clk) disable iff (!rst_n) !ien |-> !if_ready);
  p_data_wins_r10: assert property (@(posedge clk) disable iff (!rst_n) (d_ack && if_req) |-> !if_ready);
  p_rd_lat_r11:    assert property (@(posedge clk) disable iff (!rst_n) (d_ack && !d_we) |=> d_rvalid);
  p_wr_quiet_r11:  assert property (@(posedge clk) disable iff (!rst_n) !(d_ack && !d_we) |=> !d_rvalid);
  p_if_lat_r11:    assert property (@(posedge clk) disable iff (!rst_n) if_ready |=> if_valid);
endmodule

// File: tb/test_ocm_dual_sram.sv
module test_ocm_dual_sram;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_sel = 0; logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic d_req = 0, d_we = 0, d_le = 0; logic [1:0] d_size = 0;
  logic [31:0] d_addr = 0, d_wdata = 0, d_rdata;
  logic d_ack, d_miss, d_rvalid;
  logic if_req = 0, if_dbl = 0; logic [31:0] if_addr = 0;
  logic if_ready, if_valid; logic [63:0] if_rdata;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  ocm_dual_sram i_ocm_dual_sram (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [31:0] v);
    @(negedge clk); cfg_we = 1; cfg_sel = sel; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic dop(input string req, input logic we, input logic [1:0] sz, input logic le,
                     input logic [31:0] a, input logic [31:0] wd, input logic [31:0] exp);
    @(negedge clk);
    d_req = 1; d_we = we; d_size = sz; d_le = le; d_addr = a; d_wdata = wd;
    #1 chk({req, " ack"}, {63'h0, d_ack}, 64'h1);
    @(negedge clk); d_req = 0; d_we = 0;
    if (!we) begin
      chk({req, " rvalid"}, {63'h0, d_rvalid}, 64'h1);
      chk(req, {32'h0, d_rdata}, {32'h0, exp});
    end else chk({req, " no rvalid"}, {63'h0, d_rvalid}, 64'h0);
  endtask

  task automatic fetch(input string req, input logic dbl, input logic [31:0] a, input logic [63:0] exp);
    @(negedge clk); if_req = 1; if_dbl = dbl; if_addr = a;
    #1 chk({req, " ready"}, {63'h0, if_ready}, 64'h1);
    @(negedge clk); if_req = 0;
    chk({req, " valid"}, {63'h0, if_valid}, 64'h1);
    chk(req, if_rdata, exp);
  endtask

  localparam int NV = 14;
  localparam logic [99:0] VEC [NV] = '{
    {4'b1_10_0, 32'h0400_0000, 32'h1122_3344, 32'h0},
    {4'b0_10_0, 32'h0400_0000, 32'h0, 32'h1122_3344},
    {4'b0_00_0, 32'h0400_0000, 32'h0, 32'h0000_0011},
    {4'b0_00_0, 32'h0400_0003, 32'h0, 32'h0000_0044},
    {4'b0_01_0, 32'h0400_0002, 32'h0, 32'h0000_3344},
    {4'b0_01_0, 32'h0400_0003, 32'h0, 32'h0000_3344},
    {4'b0_10_1, 32'h0400_0000, 32'h0, 32'h4433_2211},
    {4'b0_01_1, 32'h0400_0002, 32'h0, 32'h0000_4433},
    {4'b1_00_0, 32'h0400_0001, 32'h0000_00AA, 32'h0},
    {4'b1_10_0, 32'h0400_0004, 32'h0, 32'h0},
    {4'b1_01_1, 32'h0400_0004, 32'h0000_BEEF, 32'h0},
    {4'b0_10_0, 32'h0400_0004, 32'h0, 32'hEFBE_0000},
    {4'b1_10_1, 32'h0400_0008, 32'hCAFE_F00D, 32'h0},
    {4'b0_10_0, 32'h0400_0008, 32'h0, 32'h0DF0_FECA}
  };

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cfg_sel = 0; #1 chk("R1 fetch reg", {32'h0, cfg_rdata}, 64'h0);
    cfg_sel = 1; #1 chk("R1 data reg", {32'h0, cfg_rdata}, 64'h0);
    d_req = 1; d_addr = 32'h0; if_req = 1; if_addr = 32'h0;
    #1 chk("R1 no ack", {62'h0, d_ack, d_miss}, 64'h1);
    chk("R1 no fetch", {63'h0, if_ready}, 64'h0);
    @(negedge clk); d_req = 0; if_req = 0;

    cfg_write(1'b0, 32'h0400_0001);
    cfg_write(1'b1, 32'hFFFF_FFFF);
    cfg_sel = 1; #1 chk("R2 readback mask", {32'h0, cfg_rdata}, 64'hFC00_0001);
    cfg_write(1'b1, 32'h0400_0001);
    cfg_sel = 0; #1 chk("R2 fetch readback", {32'h0, cfg_rdata}, 64'h0400_0001);

    for (int i = 0; i < NV; i++)
      dop($sformatf("R5/R6/R7 vector %0d", i), VEC[i][99], VEC[i][98:97], VEC[i][96],
          VEC[i][95:64], VEC[i][63:32], VEC[i][31:0]);

    dop("R4 data alias", 1'b0, 2'd2, 1'b0, 32'h0555_5008, 32'h0, 32'h0DF0_FECA);
    dop("R6 byte le unaffected R7", 1'b0, 2'd0, 1'b1, 32'h0400_000B, 32'h0, 32'h0000_00CA);

    @(negedge clk); d_req = 1; d_we = 1; d_size = 2; d_addr = 32'h0800_0000; d_wdata = 32'h0;
    #1 chk("R3 window miss", {62'h0, d_ack, d_miss}, 64'h1);
    @(negedge clk); d_req = 0; d_we = 0;
    dop("R3 miss stored nothing", 1'b0, 2'd2, 1'b0, 32'h0400_0000, 32'h0, 32'h11AA_3344);

    fetch("R8 single word0", 1'b0, 32'h0400_0003, {32'h11AA_3344, 32'h0});
    fetch("R8 single word1", 1'b0, 32'h0400_0006, {32'hEFBE_0000, 32'h0});
    fetch("R8 double aligned down", 1'b1, 32'h0400_0004, {32'h11AA_3344, 32'hEFBE_0000});
    fetch("R4 fetch alias", 1'b1, 32'h06FF_F000, {32'h11AA_3344, 32'hEFBE_0000});

    @(negedge clk); if_req = 1; if_dbl = 0; if_addr = 32'h0400_0000;
    d_req = 1; d_we = 0; d_size = 2; d_le = 0; d_addr = 32'h0400_0008;
    #1 chk("R10 data wins", {62'h0, d_ack, if_ready}, 64'h2);
    @(negedge clk); d_req = 0;
    chk("R11 data read lat", {63'h0, d_rvalid}, 64'h1);
    chk("R10 data result", {32'h0, d_rdata}, 64'h0DF0_FECA);
    #1 chk("R10 fetch after", {63'h0, if_ready}, 64'h1);
    @(negedge clk); if_req = 0;
    chk("R11 fetch lat", {63'h0, if_valid}, 64'h1);
    chk("R10 fetch data", if_rdata, {32'h11AA_3344, 32'h0});

    cfg_write(1'b0, 32'h0800_0001);
    @(negedge clk); if_req = 1; if_addr = 32'h0400_0000;
    #1 chk("R9 base mismatch", {63'h0, if_ready}, 64'h0);
    if_addr = 32'h0800_0000;
    #1 chk("R9 base match", {63'h0, if_ready}, 64'h1);
    @(negedge clk); if_req = 0;
    cfg_write(1'b0, 32'h0800_0000);
    @(negedge clk); if_req = 1;
    #1 chk("R9 fetch disabled", {63'h0, if_ready}, 64'h0);
    @(negedge clk); if_req = 0;

    cfg_write(1'b1, 32'h0400_0000);
    @(negedge clk); d_req = 1; d_we = 1; d_size = 2; d_addr = 32'h0400_0000; d_wdata = 32'hDEAD_BEEF;
    #1 chk("R3 data disabled", {62'h0, d_ack, d_miss}, 64'h1);
    @(negedge clk); d_req = 0; d_we = 0;
    cfg_write(1'b1, 32'h0400_0001);
    dop("R3 disabled stored nothing", 1'b0, 2'd2, 1'b0, 32'h0400_0000, 32'h0, 32'h11AA_3344);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule